// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits on the write path of a memory controller, just ahead of the DRAM. Each accepted transfer is a 512-bit cache line made of eight 64-bit quad-words, plus one even-parity bit per data byte. For every quad-word the block builds an 8-bit SEC-DED check byte. The line data and the eight check bytes then leave through a single register stage.

Two diagnostic features can deliberately damage the check bytes:

- **Inversion.** A 16-bit invert mask is XORed onto the check bytes of one programmable quad-word pair. Its upper byte goes to the higher quad-word of the pair and its lower byte to the lower quad-word.
- **Poisoning.** When enabled, any quad-word whose incoming byte parity is wrong gets a fixed pattern XORed into its check byte. A later read then sees an uncorrectable error.

A plain control register holds the pair selector, the mask and the poison enable, and its contents are reflected on read-back outputs.

Both streaming sides use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. The output holds its line and check bytes for as long as `m_ready` is low. `s_ready` is high whenever the output stage is empty or is being drained in the same cycle. Software writes the control fields by pulsing `cfg_we`.

Top module: `ecc_wr_injector`

## Requirements
- R1: Quad-word n is line bits [64n+63:64n]. Its check byte is built as follows:
  - Data bit i is given the i-th integer, counting from 0, among the values 3..71 that are not powers of two.
  - Check bit j (j = 0..6) is the XOR of the data bits whose value has bit j set.
  - Check bit 7 is the XOR of all 64 data bits and check bits 6:0.
  - The check byte of quad-word n appears on `m_ecc[8n+7:8n]`.
- R2: The pair selector picks the target pair. Code 0 targets quad-words 0/1, code 1 targets 2/3, code 2 targets 4/5, and code 3 targets 6/7.
- R3: Mask bits 15:8 are XORed onto the check byte of the higher quad-word of the selected pair. Mask bits 7:0 are XORed onto the check byte of the lower one, bit k onto check bit k.
- R4: Check bits whose mask bit is 0 are unchanged, and quad-words outside the selected pair never receive the mask.
- R5: With poison disabled, every check byte is the correct code, even when the input parity is wrong.
- R6: Input parity is even per byte: parity bit 8n+b goes with data byte 8n+b. With poison enabled, a quad-word with any byte parity mismatch has 8'h03 XORed into its check byte. Other quad-words are unaffected.
- R7: Inversion applies whatever the poison setting is. When both apply to one quad-word, both patterns are XORed in.
- R8: After reset the control fields read back as zero. A cycle with `cfg_we` high loads all three fields, and they are held otherwise.
- R9: A line accepted on an edge appears on the output after exactly that edge, with `m_valid` high and the data unchanged. The stage empties when it is drained and nothing new is accepted.
- R10: While `m_valid` is high and `m_ready` is low, `s_ready` is low and the output data and check bytes stay stable.
- R11: A line accepted on the same edge as a control write uses the old control values. The next accepted line uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_poison_en_i | input | 1 | Poison enable to write |
| cfg_pair_sel_i | input | 2 | Pair selector to write |
| cfg_inv_mask_i | input | 16 | Invert mask to write |
| cfg_poison_en_o | output | 1 | Poison enable read-back |
| cfg_pair_sel_o | output | 2 | Pair selector read-back |
| cfg_inv_mask_o | output | 16 | Invert mask read-back |
| s_valid | input | 1 | Input line valid |
| s_ready | output | 1 | Input line accepted when high with s_valid |
| s_data | input | 512 | Input cache line |
| s_par | input | 64 | Even parity, one bit per data byte |
| m_valid | output | 1 | Output line valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 512 | Output cache line |
| m_ecc | output | 64 | Check bytes, byte n for quad-word n |

## Verification
Random lines with clean parity and a zero mask compare the check bytes against an independent syndrome model. Under this pattern, an error in the code columns shows up apart from any injection effect. Each selector code is then tried with a mask whose two halves differ, which separates a wrong pair from swapped halves. Random masks with random parity faults, with poison on and off, separate the poison gating from the inversion. A back-pressure run and a control write coinciding with an accepted line check the stage timing and when the control takes effect.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int QW_W    = 64;
  localparam int ECC_W   = 8;
  localparam int SYN_W   = 7;
  localparam int BYTES_QW = QW_W / 8;
  localparam logic [ECC_W-1:0] POISON_PAT = 8'h03;

  typedef struct packed {
    logic        poison_en;
    logic [1:0]  pair_sel;
    logic [15:0] inv_mask;
  } inj_cfg_t;

  // Code column of data bit idx: idx-th non-power-of-two value from 3 upward
  function automatic logic [SYN_W-1:0] col_value(input int idx);
    int n;
    logic [SYN_W-1:0] res;
    n   = 0;
    res = '0;
    for (int k = 3; k < 128; k++) begin
      if ((k & (k - 1)) != 0) begin
        if (n == idx) res = SYN_W'(k);
        n++;
      end
    end
    return res;
  endfunction

  // Data bits contributing to check bit j
  function automatic logic [QW_W-1:0] check_cover(input int j);
    logic [QW_W-1:0] m;
    logic [SYN_W-1:0] c;
    for (int i = 0; i < QW_W; i++) begin
      c    = col_value(i);
      m[i] = c[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_inj_cfg.sv
module ecc_inj_cfg
  import ecc_inj_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  inj_cfg_t wr_cfg,
  output inj_cfg_t cur_cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cur_cfg <= '0;
    else if (we) cur_cfg <= wr_cfg;
  end
endmodule

// File: rtl/ecc_inj_lane.sv
module ecc_inj_lane
  import ecc_inj_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int SEL_W = 2
)(
  input  logic [QW_W-1:0]     qw,
  input  logic [BYTES_QW-1:0] par,
  input  logic [SEL_W-1:0]    pair_sel,
  input  logic [2*ECC_W-1:0]  inv_mask,
  input  logic                poison_en,
  output logic [ECC_W-1:0]    ecc
);
  localparam logic [SEL_W-1:0] MY_PAIR = SEL_W'(IDX / 2);
  localparam bit               IS_HIGH = (IDX % 2) == 1;

  logic [SYN_W-1:0]    syn;
  logic [ECC_W-1:0]    clean;
  logic [BYTES_QW-1:0] byte_bad;
  logic                qw_bad;
  logic [ECC_W-1:0]    mask_part;
  logic                hit;

  always_comb begin
    for (int j = 0; j < SYN_W; j++) syn[j] = ^(qw & check_cover(j));
    clean = {(^qw) ^ (^syn), syn};
  end

  always_comb begin
    for (int b = 0; b < BYTES_QW; b++) byte_bad[b] = (^qw[8*b +: 8]) ^ par[b];
    qw_bad = |byte_bad;
  end

  generate
    if (IS_HIGH) begin : g_hi
      assign mask_part = inv_mask[2*ECC_W-1:ECC_W];
    end else begin : g_lo
      assign mask_part = inv_mask[ECC_W-1:0];
    end
  endgenerate

  assign hit = (pair_sel == MY_PAIR);
  assign ecc = clean
             ^ (hit ? mask_part : '0)
             ^ ((poison_en && qw_bad) ? POISON_PAT : '0);
endmodule

// File: rtl/ecc_inj_stage.sv
module ecc_inj_stage #(
  parameter int DATA_W = 512,
  parameter int ECC_T  = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ECC_T-1:0]  in_ecc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ECC_T-1:0]  out_ecc
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      out_data <= in_data;
      out_ecc  <= in_ecc;
    end
  end
endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector
  import ecc_inj_pkg::*;
#(
  parameter int QW_N   = 8,
  parameter int LINE_W = QW_N * QW_W,
  parameter int PAR_W  = QW_N * BYTES_QW,
  parameter int ECC_T  = QW_N * ECC_W,
  parameter int SEL_W  = $clog2(QW_N / 2)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_poison_en_i,
  input  logic [SEL_W-1:0]  cfg_pair_sel_i,
  input  logic [15:0]       cfg_inv_mask_i,
  output logic              cfg_poison_en_o,
  output logic [SEL_W-1:0]  cfg_pair_sel_o,
  output logic [15:0]       cfg_inv_mask_o,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [LINE_W-1:0] s_data,
  input  logic [PAR_W-1:0]  s_par,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [LINE_W-1:0] m_data,
  output logic [ECC_T-1:0]  m_ecc
);
  inj_cfg_t wr_cfg, cur_cfg;
  logic [ECC_T-1:0] ecc_next;

  assign wr_cfg = '{poison_en: cfg_poison_en_i,
                    pair_sel:  2'(cfg_pair_sel_i),
                    inv_mask:  cfg_inv_mask_i};

  ecc_inj_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wr_cfg  (wr_cfg),
    .cur_cfg (cur_cfg)
  );

  assign cfg_poison_en_o = cur_cfg.poison_en;
  assign cfg_pair_sel_o  = SEL_W'(cur_cfg.pair_sel);
  assign cfg_inv_mask_o  = cur_cfg.inv_mask;

  generate
    for (genvar q = 0; q < QW_N; q++) begin : g_lane
      ecc_inj_lane #(.IDX(q), .SEL_W(SEL_W)) u_lane (
        .qw        (s_data[q*QW_W +: QW_W]),
        .par       (s_par[q*BYTES_QW +: BYTES_QW]),
        .pair_sel  (SEL_W'(cur_cfg.pair_sel)),
        .inv_mask  (cur_cfg.inv_mask),
        .poison_en (cur_cfg.poison_en),
        .ecc       (ecc_next[q*ECC_W +: ECC_W])
      );
    end
  endgenerate

  ecc_inj_stage #(.DATA_W(LINE_W), .ECC_T(ECC_T)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (s_data),
    .in_ecc    (ecc_next),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (m_data),
    .out_ecc   (m_ecc)
  );
endmodule

// File: rtl/ecc_inj_chk.sv
module ecc_inj_chk #(
  parameter int LINE_W = 512,
  parameter int ECC_T  = 64,
  parameter int SEL_W  = 2
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_poison_en_i,
  input logic [SEL_W-1:0]  cfg_pair_sel_i,
  input logic [15:0]       cfg_inv_mask_i,
  input logic              cfg_poison_en_o,
  input logic [SEL_W-1:0]  cfg_pair_sel_o,
  input logic [15:0]       cfg_inv_mask_o,
  input logic              s_valid,
  input logic              s_ready,
  input logic [LINE_W-1:0] s_data,
  input logic              m_valid,
  input logic              m_ready,
  input logic [LINE_W-1:0] m_data,
  input logic [ECC_T-1:0]  m_ecc
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_ecc));
  // R10
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);
  // R9
  accept_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid && (m_data == $past(s_data)));
  // R9
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid && m_ready |=> !m_valid);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable({cfg_poison_en_o, cfg_pair_sel_o, cfg_inv_mask_o}));
  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> {cfg_poison_en_o, cfg_pair_sel_o, cfg_inv_mask_o}
               == $past({cfg_poison_en_i, cfg_pair_sel_i, cfg_inv_mask_i}));
endmodule

bind ecc_wr_injector ecc_inj_chk #(.LINE_W(LINE_W), .ECC_T(ECC_T), .SEL_W(SEL_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_we          (cfg_we),
  .cfg_poison_en_i (cfg_poison_en_i),
  .cfg_pair_sel_i  (cfg_pair_sel_i),
  .cfg_inv_mask_i  (cfg_inv_mask_i),
  .cfg_poison_en_o (cfg_poison_en_o),
  .cfg_pair_sel_o  (cfg_pair_sel_o),
  .cfg_inv_mask_o  (cfg_inv_mask_o),
  .s_valid         (s_valid),
  .s_ready         (s_ready),
  .s_data          (s_data),
  .m_valid         (m_valid),
  .m_ready         (m_ready),
  .m_data          (m_data),
  .m_ecc           (m_ecc)
);

// File: tb/test_ecc_wr_injector.sv
`timescale 1ns/1ps
module test_ecc_wr_injector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic         cfg_poison_en_i = 1'b0;
  logic [1:0]   cfg_pair_sel_i = '0;
  logic [15:0]  cfg_inv_mask_i = '0;
  logic         cfg_poison_en_o;
  logic [1:0]   cfg_pair_sel_o;
  logic [15:0]  cfg_inv_mask_o;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [511:0] s_data = '0;
  logic [63:0]  s_par = '0;
  logic         m_valid;
  logic         m_ready = 1'b1;
  logic [511:0] m_data;
  logic [63:0]  m_ecc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model of the control fields
  logic        mp_en = 1'b0;
  logic [1:0]  mp_sel = '0;
  logic [15:0] mp_mask = '0;

  always #2 clk = ~clk;

  ecc_wr_injector i_ecc_wr_injector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_poison_en_i(cfg_poison_en_i), .cfg_pair_sel_i(cfg_pair_sel_i),
    .cfg_inv_mask_i(cfg_inv_mask_i), .cfg_poison_en_o(cfg_poison_en_o),
    .cfg_pair_sel_o(cfg_pair_sel_o), .cfg_inv_mask_o(cfg_inv_mask_o),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_par(s_par),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_ecc(m_ecc)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [6:0] pos_of(input int idx);
    int n = 0;
    int k = 2;
    while (1) begin
      k++;
      if ((k & (k - 1)) == 0) continue;
      if (n == idx) return 7'(k);
      n++;
    end
  endfunction

  // syndrome-sum reference check byte
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [6:0] s = '0;
    logic       p = 1'b0;
    for (int i = 0; i < 64; i++) if (d[i]) begin s ^= pos_of(i); p ^= 1'b1; end
    for (int j = 0; j < 7; j++) p ^= s[j];
    return {p, s};
  endfunction

  function automatic logic [63:0] good_par(input logic [511:0] d);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) r[b] = ^d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [63:0] exp_ecc(input logic [511:0] d, input logic [63:0] p,
                                          input logic en, input logic [1:0] sel,
                                          input logic [15:0] mk);
    logic [63:0] r;
    logic [63:0] gp = good_par(d);
    for (int q = 0; q < 8; q++) begin
      logic [7:0] e = ref_chk(d[64*q +: 64]);
      if (q / 2 == int'(sel)) e ^= (q % 2 == 1) ? mk[15:8] : mk[7:0];
      if (en && (gp[8*q +: 8] != p[8*q +: 8])) e ^= 8'h03;
      r[8*q +: 8] = e;
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd_line();
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[32*w +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic en, input logic [1:0] sel, input logic [15:0] mk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_poison_en_i = en; cfg_pair_sel_i = sel; cfg_inv_mask_i = mk;
    @(posedge clk);
    mp_en = en; mp_sel = sel; mp_mask = mk;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one line through with m_ready high; checks data and check bytes
  task automatic send(input logic [511:0] d, input logic [63:0] p, input string req);
    logic [63:0] e;
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_par = p;
    e = exp_ecc(d, p, mp_en, mp_sel, mp_mask);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    check(m_valid == 1'b1, "R9", "valid after one edge", 512'(m_valid), 512'(1));
    check(m_data == d, "R9", "data unchanged", m_data, d);
    check(m_ecc == e, req, "check bytes", 512'(m_ecc), 512'(e));
  endtask

  initial begin
    logic [511:0] d, d2;
    logic [63:0]  p, e;
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check(cfg_poison_en_o == 1'b0 && cfg_pair_sel_o == 2'd0 && cfg_inv_mask_o == 16'h0,
          "R8", "reset fields", 512'({cfg_poison_en_o, cfg_pair_sel_o, cfg_inv_mask_o}), 512'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(m_valid == 1'b0, "R9", "empty after reset", 512'(m_valid), 512'(0));

    // R1 directed: zero line, single bits, all ones
    send('0, '0, "R1");
    d = '0; d[0] = 1'b1; d[64*5 + 63] = 1'b1; send(d, good_par(d), "R1");
    d = '1; send(d, good_par(d), "R1");
    // R1 random, clean parity, zero mask
    for (int t = 0; t < 20; t++) begin d = rnd_line(); send(d, good_par(d), "R1"); end

    // R2 / R3 / R4: each selector with distinct halves
    for (int s = 0; s < 4; s++) begin
      write_cfg(1'b0, 2'(s), 16'hA501);
      d = rnd_line(); send(d, good_par(d), "R2");
      write_cfg(1'b0, 2'(s), 16'h8000);
      d = rnd_line(); send(d, good_par(d), "R3");
    end
    for (int t = 0; t < 20; t++) begin
      write_cfg(1'b0, 2'($urandom), 16'($urandom));
      d = rnd_line(); send(d, good_par(d), "R4");
    end

    // R5: poison off, broken parity gives clean code
    write_cfg(1'b0, 2'd1, 16'h0);
    for (int t = 0; t < 10; t++) begin
      d = rnd_line(); p = good_par(d) ^ 64'($urandom);
      send(d, p, "R5");
    end
    // R6: poison on, one bad byte in quad-word 6
    write_cfg(1'b1, 2'd0, 16'h0);
    d = rnd_line(); p = good_par(d); p[8*6 + 3] = ~p[8*6 + 3];
    send(d, p, "R6");
    check(m_ecc[8*6 +: 8] == (ref_chk(d[64*6 +: 64]) ^ 8'h03), "R6", "poisoned byte",
          512'(m_ecc[8*6 +: 8]), 512'(ref_chk(d[64*6 +: 64]) ^ 8'h03));
    check(m_ecc[8*5 +: 8] == ref_chk(d[64*5 +: 64]), "R6", "neighbour untouched",
          512'(m_ecc[8*5 +: 8]), 512'(ref_chk(d[64*5 +: 64])));
    for (int t = 0; t < 10; t++) begin
      d = rnd_line(); p = good_par(d) ^ (64'($urandom) & 64'($urandom));
      send(d, p, "R6");
    end
    // R7: poison and inversion both on same quad-word, random mixes
    write_cfg(1'b1, 2'd3, 16'h0F10);
    d = rnd_line(); p = good_par(d); p[63] = ~p[63];
    send(d, p, "R7");
    for (int t = 0; t < 10; t++) begin
      write_cfg(1'($urandom), 2'($urandom), 16'($urandom));
      d = rnd_line(); p = good_par(d) ^ 64'($urandom);
      send(d, p, "R7");
    end

    // R11: control write on the same edge as an accepted line
    write_cfg(1'b0, 2'd2, 16'h00FF);
    d = rnd_line(); d2 = rnd_line();
    @(negedge clk);
    e = exp_ecc(d, good_par(d), 1'b0, 2'd2, 16'h00FF);
    s_valid = 1'b1; s_data = d; s_par = good_par(d);
    cfg_we = 1'b1; cfg_poison_en_i = 1'b0; cfg_pair_sel_i = 2'd0; cfg_inv_mask_i = 16'hFF00;
    @(posedge clk);
    mp_sel = 2'd0; mp_mask = 16'hFF00;
    @(negedge clk);
    cfg_we = 1'b0; s_valid = 1'b0;
    check(m_ecc == e, "R11", "old control on same edge", 512'(m_ecc), 512'(e));
    check(cfg_inv_mask_o == 16'hFF00, "R8", "mask read-back", 512'(cfg_inv_mask_o), 512'(16'hFF00));
    send(d2, good_par(d2), "R11");

    // R10: back-pressure
    d = rnd_line(); d2 = rnd_line();
    @(negedge clk);
    m_ready = 1'b0; s_valid = 1'b1; s_data = d; s_par = good_par(d);
    e = exp_ecc(d, good_par(d), mp_en, mp_sel, mp_mask);
    @(posedge clk);
    @(negedge clk);
    s_data = d2; s_par = good_par(d2);
    for (int t = 0; t < 3; t++) begin
      check(s_ready == 1'b0, "R10", "ready low when stalled", 512'(s_ready), 512'(0));
      check(m_valid && m_data == d && m_ecc == e, "R10", "output held", m_data, d);
      @(negedge clk);
    end
    m_ready = 1'b1;
    e = exp_ecc(d2, good_par(d2), mp_en, mp_sel, mp_mask);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    check(m_valid && m_data == d2 && m_ecc == e, "R10", "next line after release", m_data, d2);
    @(negedge clk);
    check(m_valid == 1'b0, "R9", "drained", 512'(m_valid), 512'(0));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule